// File: doc/BRIEF.md
# Return-from-Trap Resolver

This block decides what a return-from-trap instruction does once it reaches execution in a small processor core. It takes the instruction's valid strobe and its one-bit debug selector. It also takes the current program counter and the live status bits: supervisor, previous-supervisor and trap-enable. Finally it takes the two saved return addresses (one for ordinary traps, one for debug traps), the two status bits saved on debug entry, and the core's debug-mode flag.

From these inputs it produces a PC redirect and the status bits the core must adopt. It also produces three single-cycle requests: halt the core, raise an illegal-instruction fault, or leave debug mode. The fault conditions are tested in a fixed priority before either return path is considered. A return that is refused or does not match the run mode falls through to the next sequential instruction.

All outputs are registered and appear exactly one clock after the valid strobe. The redirect target and the status bits hold their last value until the next instruction arrives.

Top module: `rett_unit`

## Requirements
- R1: While `rst_n` is sampled low, every output is 0 on the following cycle.
- R2: `redir_valid` is 1 in exactly the cycle after a cycle with `rett_valid`=1, and 0 otherwise. In a cycle after `rett_valid`=0, `next_pc`, `new_s` and `new_et` keep their previous values.
- R3: When `psr_s`=0 and `psr_et`=0, the result has `halt_req`=1 and `next_pc` = `cur_pc`+4. `new_s`/`new_et` equal `psr_s`/`psr_et`, and no other request is raised.
- R4: When `psr_s`=0 and `psr_et`=1, the result has `next_pc` = `cur_pc`+4 with status unchanged and no request, whatever the debug inputs are.
- R5: When `psr_s`=1 and `psr_et`=1, the result has `illegal_req`=1 and `next_pc` = `cur_pc`+4 with status unchanged, whatever `debug_mode` and `dbg_field` are.
- R6: When `psr_s`=1, `psr_et`=0, `debug_mode`=0 and `dbg_field`=0, the result has `next_pc` = `save_pc`, `new_et`=1 and `new_s` = `psr_ps`, with no request.
- R7: When `psr_s`=1, `psr_et`=0, `debug_mode`=1 and `dbg_field`=1, the result has `next_pc` = `dbg_save_pc`, `new_et` = `dbg_save_et`, `new_s` = `dbg_save_s` and `dbg_exit`=1.
- R8: When `psr_s`=1 and `psr_et`=0 but `debug_mode` differs from `dbg_field`, the result has `next_pc` = `cur_pc`+4 with status unchanged and no request.
- R9: At most one of `halt_req`, `illegal_req`, `dbg_exit` is 1 in any cycle, and each appears only together with `redir_valid`.
- R10: The sequential address `cur_pc`+4 wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rett_valid | input | 1 | Return-from-trap instruction present this cycle |
| dbg_field | input | 1 | Debug selector bit of the instruction |
| cur_pc | input | AW | Address of the instruction |
| psr_s | input | 1 | Current supervisor bit |
| psr_ps | input | 1 | Previous supervisor bit |
| psr_et | input | 1 | Current trap-enable bit |
| save_pc | input | AW | Return address saved on an ordinary trap |
| dbg_save_pc | input | AW | Return address saved on debug entry |
| dbg_save_s | input | 1 | Supervisor bit saved on debug entry |
| dbg_save_et | input | 1 | Trap-enable bit saved on debug entry |
| debug_mode | input | 1 | Core is in debug run mode |
| redir_valid | output | 1 | Redirect and status update valid this cycle |
| next_pc | output | AW | Redirect target |
| new_s | output | 1 | Supervisor bit to adopt |
| new_et | output | 1 | Trap-enable bit to adopt |
| dbg_exit | output | 1 | Pulse: leave debug mode |
| halt_req | output | 1 | Pulse: halt the core |
| illegal_req | output | 1 | Pulse: raise illegal-instruction fault |

## Verification
The assertions check on every cycle the one-cycle timing of the redirect, the holding of the target and status between instructions, the mutual exclusion of the three requests, and the outcome of each priority class against the inputs of the previous cycle. The bench's reference model, compared every clock, is what shows the PC wrap at the top of the address space. Its scenarios also show that the lower-priority return paths really are masked by the fault conditions for every combination of debug inputs, and that long runs of mixed instructions keep the outputs coherent.

// File: rtl/rett_pkg.sv
// Package: shared types for the return-from-trap resolver.
// Assumes: nothing beyond a 1800-2017 compiler.
package rett_pkg;

    // Outcome classes, listed in descending priority of the checks.
    typedef enum logic [2:0] {
        CLS_USER_HALT  = 3'd0,
        CLS_USER_SKIP  = 3'd1,
        CLS_ILLEGAL    = 3'd2,
        CLS_NORMAL_RET = 3'd3,
        CLS_DEBUG_RET  = 3'd4,
        CLS_PASS       = 3'd5
    } rett_class_e;

    typedef struct packed {
        logic s;
        logic et;
    } rett_status_t;

    typedef struct packed {
        logic halt;
        logic illegal;
        logic dbg_exit;
    } rett_req_t;

endpackage

// File: rtl/rett_classify.sv
// Module: rett_classify
// Sorts a return-from-trap into one outcome class using a fixed priority:
// user-mode checks first, then the supervisor trap-enable fault, then the
// two return paths, and finally the fall-through.
// Assumes: inputs are stable for the cycle; purely combinational.
module rett_classify
    import rett_pkg::*;
(
    input  logic        psr_s,
    input  logic        psr_et,
    input  logic        debug_mode,
    input  logic        dbg_field,
    output rett_class_e cls
);

    // Priority decode of the privilege, enable and mode conditions.
    always_comb begin
        if (!psr_s) begin
            cls = psr_et ? CLS_USER_SKIP : CLS_USER_HALT;
        end else if (psr_et) begin
            cls = CLS_ILLEGAL;
        end else if (!debug_mode && !dbg_field) begin
            cls = CLS_NORMAL_RET;
        end else if (debug_mode && dbg_field) begin
            cls = CLS_DEBUG_RET;
        end else begin
            cls = CLS_PASS;
        end
    end

endmodule

// File: rtl/rett_resolve.sv
// Module: rett_resolve
// Turns an outcome class into a redirect target, the status to adopt and
// the request pulses to raise.
// Assumes: AW is at least 3 so the step fits; purely combinational.
module rett_resolve
    import rett_pkg::*;
#(
    parameter int AW      = 32,
    parameter int PC_STEP = 4
) (
    input  rett_class_e  cls,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] save_pc,
    input  logic [AW-1:0] dbg_save_pc,
    input  rett_status_t  cur_status,
    input  logic          psr_ps,
    input  rett_status_t  dbg_status,
    output logic [AW-1:0] tgt_pc,
    output rett_status_t  tgt_status,
    output rett_req_t     req
);

    localparam logic [AW-1:0] STEP_V = AW'(PC_STEP);

    logic [AW-1:0] seq_pc;

    // Sequential address, wrapping at the top of the address space.
    always_comb seq_pc = cur_pc + STEP_V;

    // Select target, status and requests for the chosen class.
    always_comb begin
        tgt_pc     = seq_pc;
        tgt_status = cur_status;
        req        = '0;
        unique case (cls)
            CLS_USER_HALT: req.halt = 1'b1;
            CLS_USER_SKIP: ;
            CLS_ILLEGAL:   req.illegal = 1'b1;
            CLS_NORMAL_RET: begin
                tgt_pc        = save_pc;
                tgt_status.et = 1'b1;
                tgt_status.s  = psr_ps;
            end
            CLS_DEBUG_RET: begin
                tgt_pc       = dbg_save_pc;
                tgt_status   = dbg_status;
                req.dbg_exit = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rett_unit.sv
// Module: rett_unit (top)
// Resolves a return-from-trap instruction and presents the redirect,
// new status bits and request pulses one clock after the valid strobe.
// Assumes: one instruction per cycle at most; synchronous active-low reset.
module rett_unit
    import rett_pkg::*;
#(
    parameter int AW      = 32,
    parameter int PC_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rett_valid,
    input  logic          dbg_field,
    input  logic [AW-1:0] cur_pc,
    input  logic          psr_s,
    input  logic          psr_ps,
    input  logic          psr_et,
    input  logic [AW-1:0] save_pc,
    input  logic [AW-1:0] dbg_save_pc,
    input  logic          dbg_save_s,
    input  logic          dbg_save_et,
    input  logic          debug_mode,
    output logic          redir_valid,
    output logic [AW-1:0] next_pc,
    output logic          new_s,
    output logic          new_et,
    output logic          dbg_exit,
    output logic          halt_req,
    output logic          illegal_req
);

    rett_class_e   cls;
    logic [AW-1:0] tgt_pc;
    rett_status_t  tgt_status;
    rett_req_t     req;
    rett_status_t  cur_status;
    rett_status_t  dbg_status;

    // Pack the live and debug-saved status bits.
    always_comb begin
        cur_status = '{s: psr_s, et: psr_et};
        dbg_status = '{s: dbg_save_s, et: dbg_save_et};
    end

    rett_classify u_classify (
        .psr_s      (psr_s),
        .psr_et     (psr_et),
        .debug_mode (debug_mode),
        .dbg_field  (dbg_field),
        .cls        (cls)
    );

    rett_resolve #(
        .AW      (AW),
        .PC_STEP (PC_STEP)
    ) u_resolve (
        .cls         (cls),
        .cur_pc      (cur_pc),
        .save_pc     (save_pc),
        .dbg_save_pc (dbg_save_pc),
        .cur_status  (cur_status),
        .psr_ps      (psr_ps),
        .dbg_status  (dbg_status),
        .tgt_pc      (tgt_pc),
        .tgt_status  (tgt_status),
        .req         (req)
    );

    // Capture target and status on a valid instruction; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc <= '0;
            new_s   <= 1'b0;
            new_et  <= 1'b0;
        end else if (rett_valid) begin
            next_pc <= tgt_pc;
            new_s   <= tgt_status.s;
            new_et  <= tgt_status.et;
        end
    end

    // Single-cycle strobes that follow the valid instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            halt_req    <= 1'b0;
            illegal_req <= 1'b0;
            dbg_exit    <= 1'b0;
        end else begin
            redir_valid <= rett_valid;
            halt_req    <= rett_valid & req.halt;
            illegal_req <= rett_valid & req.illegal;
            dbg_exit    <= rett_valid & req.dbg_exit;
        end
    end

endmodule

// File: rtl/rett_unit_checker.sv
// Module: rett_unit_checker
// Temporal properties of rett_unit, attached through bind.
// Assumes: same parameters as the bound instance.
module rett_unit_checker #(
    parameter int AW      = 32,
    parameter int PC_STEP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rett_valid,
    input logic          dbg_field,
    input logic [AW-1:0] cur_pc,
    input logic          psr_s,
    input logic          psr_ps,
    input logic          psr_et,
    input logic [AW-1:0] save_pc,
    input logic [AW-1:0] dbg_save_pc,
    input logic          dbg_save_s,
    input logic          dbg_save_et,
    input logic          debug_mode,
    input logic          redir_valid,
    input logic [AW-1:0] next_pc,
    input logic          new_s,
    input logic          new_et,
    input logic          dbg_exit,
    input logic          halt_req,
    input logic          illegal_req
);

    localparam logic [AW-1:0] STEP_V = AW'(PC_STEP);

    p_redirect_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rett_valid |=> redir_valid);

    p_no_redirect_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rett_valid |=> !redir_valid && $stable(next_pc) && $stable(new_s) && $stable(new_et));

    p_halt_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rett_valid && !psr_s && !psr_et |=> halt_req && next_pc == $past(cur_pc) + STEP_V
            && !new_s && !new_et);

    p_skip_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rett_valid && !psr_s && psr_et |=> !halt_req && !illegal_req && !dbg_exit
            && next_pc == $past(cur_pc) + STEP_V);

    p_illegal_sup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rett_valid && psr_s && psr_et |=> illegal_req && next_pc == $past(cur_pc) + STEP_V
            && new_s && new_et);

    p_normal_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rett_valid && psr_s && !psr_et && !debug_mode && !dbg_field |=>
            next_pc == $past(save_pc) && new_et && new_s == $past(psr_ps) && !dbg_exit);

    p_debug_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rett_valid && psr_s && !psr_et && debug_mode && dbg_field |=>
            dbg_exit && next_pc == $past(dbg_save_pc) && new_s == $past(dbg_save_s)
            && new_et == $past(dbg_save_et));

    p_mismatch_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rett_valid && psr_s && !psr_et && (debug_mode != dbg_field) |=>
            !dbg_exit && !halt_req && !illegal_req && next_pc == $past(cur_pc) + STEP_V);

    p_req_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_req, illegal_req, dbg_exit}));

    p_req_with_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req || illegal_req || dbg_exit) |-> redir_valid);

endmodule

bind rett_unit rett_unit_checker #(.AW(AW), .PC_STEP(PC_STEP)) u_checker (.*);

// File: tb/rett_unit_bench.sv
// Bench: behavioural reference model compared against rett_unit every clock.
module rett_unit_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rett_valid, dbg_field, psr_s, psr_ps, psr_et;
    logic          dbg_save_s, dbg_save_et, debug_mode;
    logic [AW-1:0] cur_pc, save_pc, dbg_save_pc;
    logic          redir_valid, new_s, new_et, dbg_exit, halt_req, illegal_req;
    logic [AW-1:0] next_pc;

    // Expected outputs from the model.
    logic          e_redir, e_s, e_et, e_dexit, e_halt, e_ill;
    logic [AW-1:0] e_pc;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    rett_unit #(.AW(AW), .PC_STEP(4)) u_rett_unit (.*);

    // Reference model: written from the requirements as an outcome table.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            {e_redir, e_s, e_et, e_dexit, e_halt, e_ill} = '0;
            e_pc = '0;
        end else begin
            e_redir = rett_valid;
            {e_dexit, e_halt, e_ill} = '0;
            if (rett_valid) begin
                e_pc = cur_pc + 32'd4;
                e_s  = psr_s;
                e_et = psr_et;
                if (psr_s == 1'b0)
                    e_halt = (psr_et == 1'b0);
                else if (psr_et == 1'b1)
                    e_ill = 1'b1;
                else if (debug_mode == 1'b0 && dbg_field == 1'b0) begin
                    e_pc = save_pc; e_et = 1'b1; e_s = psr_ps;
                end else if (debug_mode == 1'b1 && dbg_field == 1'b1) begin
                    e_pc = dbg_save_pc; e_et = dbg_save_et; e_s = dbg_save_s;
                    e_dexit = 1'b1;
                end
            end
        end
    end

    task automatic compare(input string tag);
        n_checks++;
        if ({redir_valid, next_pc, new_s, new_et, dbg_exit, halt_req, illegal_req} !==
            {e_redir, e_pc, e_s, e_et, e_dexit, e_halt, e_ill}) begin
            n_fail++;
            $display("FAIL %s: got rv=%b pc=%h s=%b et=%b dx=%b h=%b il=%b exp rv=%b pc=%h s=%b et=%b dx=%b h=%b il=%b",
                     tag, redir_valid, next_pc, new_s, new_et, dbg_exit, halt_req, illegal_req,
                     e_redir, e_pc, e_s, e_et, e_dexit, e_halt, e_ill);
        end
    endtask

    // Advance one clock and compare on the falling edge.
    task automatic tick(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic issue(input logic s, input logic et, input logic dm, input logic df,
                         input string tag);
        rett_valid = 1'b1; psr_s = s; psr_et = et; debug_mode = dm; dbg_field = df;
        tick(tag);
        rett_valid = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        wait (cycles > 100000);
        n_fail++;
        $display("FAIL watchdog: got cycles=%0d exp below 100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rett_valid = 1'b0; dbg_field = 1'b0; psr_s = 1'b0; psr_ps = 1'b0;
        psr_et = 1'b0; dbg_save_s = 1'b0; dbg_save_et = 1'b0; debug_mode = 1'b0;
        cur_pc = 32'h0000_1000; save_pc = 32'h0000_2460; dbg_save_pc = 32'h0000_7F00;
        @(negedge clk);
        rett_valid = 1'b1; psr_s = 1'b1; // valid during reset must be ignored
        tick("R1");
        tick("R1");
        rett_valid = 1'b0;
        rst_n = 1'b1;
        tick("R2");

        // R3: user mode, traps disabled
        issue(1'b0, 1'b0, 1'b0, 1'b0, "R3");
        issue(1'b0, 1'b0, 1'b1, 1'b1, "R3");
        // R4: user mode, traps enabled
        issue(1'b0, 1'b1, 1'b0, 1'b0, "R4");
        issue(1'b0, 1'b1, 1'b1, 1'b1, "R4");
        // R5: supervisor with traps enabled masks both return paths
        for (int k = 0; k < 4; k++) issue(1'b1, 1'b1, k[1], k[0], "R5");
        // R6: normal return, previous supervisor 0 then 1
        psr_ps = 1'b0; save_pc = 32'h0000_3004;
        issue(1'b1, 1'b0, 1'b0, 1'b0, "R6");
        psr_ps = 1'b1; save_pc = 32'h0040_0000;
        issue(1'b1, 1'b0, 1'b0, 1'b0, "R6");
        // R7: debug return with each saved status pattern
        for (int k = 0; k < 4; k++) begin
            dbg_save_s = k[1]; dbg_save_et = k[0]; dbg_save_pc = 32'h0000_8000 + 32'(k * 16);
            issue(1'b1, 1'b0, 1'b1, 1'b1, "R7");
        end
        // R8: mode and field disagree
        issue(1'b1, 1'b0, 1'b1, 1'b0, "R8");
        issue(1'b1, 1'b0, 1'b0, 1'b1, "R8");
        // R2: idle cycles hold the last result
        tick("R2");
        cur_pc = 32'h1234_5678; save_pc = 32'hDEAD_0000;
        tick("R2");
        // R10: sequential address wraps
        cur_pc = 32'hFFFF_FFFC;
        issue(1'b0, 1'b1, 1'b0, 1'b0, "R10");
        cur_pc = 32'hFFFF_FFFE;
        issue(1'b1, 1'b1, 1'b0, 1'b0, "R10");
        // R9: mixed stream, back-to-back and gapped
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            rett_valid = r[0] | r[1]; psr_s = r[2]; psr_et = r[3]; debug_mode = r[4];
            dbg_field = r[5]; psr_ps = r[6]; dbg_save_s = r[7]; dbg_save_et = r[8];
            cur_pc = $urandom; save_pc = $urandom; dbg_save_pc = $urandom;
            tick("R9");
        end
        rett_valid = 1'b0;
        tick("R2");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule